// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds or subtracts two 32-bit binary floating-point numbers in the standard single-precision layout. An operation select chooses `a + b` or `a - b`. Each operand is broken into sign, biased exponent and fraction. The implicit leading one is restored for normal values, and subnormals keep a leading zero. The magnitudes are then aligned, combined, normalised and rounded to nearest with ties to even.

A request is presented with `in_valid` high. The rounded result and its flags come back on the next clock edge with `out_valid` high. The three flags report overflow to infinity, an inexact tiny result, and an invalid operation. Only the single rounding mode is provided, and nothing traps.

Top module: `fp_add_sp`

## Requirements
- R1: Operands use bit 31 as the sign, bits 30..23 as the exponent biased by 127, and bits 22..0 as the fraction. A normal operand is handled as 1.F, so 0x3F400000 + 0x40880000 gives 0x40A00000 and 1.0 + 1.0 gives 0x40000000.
- R2: With `op` = 1 the block computes a - b, and with `op` = 0 it computes a + b. Whether the magnitudes are added or subtracted follows from both signs and `op`. A result that needs a left shift to normalise, such as -12.625 + 24.5 = 0x413E0000, is normalised.
- R3: The operand with the smaller exponent is shifted right by the exponent difference, and the result takes the larger exponent. Every bit shifted below the round position is ORed into the sticky bit, so 1.0 + 2^-30 gives exactly 0x3F800000.
- R4: Rounding is to nearest. An exact tie goes to the even fraction, so 1.0 + 2^-24 gives 0x3F800000 and 0x3F800001 + 2^-24 gives 0x3F800002. Anything above half rounds up.
- R5: A rounding step that carries out of the 24-bit significand shifts the result right once and raises the exponent by one, so 0x3FFFFFFF + 2^-24 gives 0x40000000.
- R6: A final exponent of 255 or more gives infinity with the result's sign and asserts `ovf`. This includes the case where the rounding carry alone causes it. At most one of `ovf`, `unf` and `inv` is high.
- R7: A NaN operand, or infinities of opposite effective sign, gives 0x7FC00000 with `inv` asserted.
- R8: An infinite operand combined with any finite operand gives that infinity, with its effective sign and no flag. Exponent 255 with a zero fraction is infinity; exponent 255 with a nonzero fraction is NaN.
- R9: An exact cancellation gives +0 (0x00000000). The sum of two zeros of equal effective sign keeps that sign, so -0 + -0 gives 0x80000000. A zero operand returns the other operand unchanged.
- R10: An exponent field of 0 marks a zero or a subnormal with leading bit 0. A result below the smallest normal exponent is returned as a subnormal or zero with exponent field 0. `unf` is asserted only if that result is inexact, so exact subnormal sums such as 0x00000001 + 0x00000001 = 0x00000002 leave it clear.
- R11: `out_valid` is 0 in reset and equals the previous cycle's `in_valid`. The flags are 0 whenever `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe for a, b and op |
| op | input | 1 | 0 = add, 1 = subtract b from a |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 32 | Rounded sum or difference |
| ovf | output | 1 | Result overflowed to infinity |
| unf | output | 1 | Tiny result that is inexact |
| inv | output | 1 | Invalid operation, quiet NaN returned |

## Verification
The rounding carry and the exponent overflow can fall in the same cycle. This happens when the largest finite value receives an addend that lands exactly on a tie with an odd fraction. The rounding increment then wraps the significand, and the renormalised exponent reaches 255. The bench provokes this with 0x7F7FFFFF + 0x73000000 and expects 0x7F800000 with `ovf` high and the other flags low. It contrasts this with the same carry at a modest exponent (0x3FFFFFFF + 2^-24), which must give plain 2.0 and no flag.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int EXT_W  = SIG_W + 3;
  localparam int EW     = EXP_W + 2;
  localparam int LZ_W   = $clog2(EXT_W + 1);
  localparam logic [EXP_W-1:0]  EXP_TOP = '1;
  localparam logic [WORD_W-1:0] QNAN    = {1'b0, EXP_TOP, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [SIG_W-1:0] sig;
    logic             nan;
    logic             inf;
    logic             zero;
  } opnd_t;

  function automatic logic [LZ_W-1:0] lead_zeros(input logic [EXT_W-1:0] v);
    logic found;
    lead_zeros = LZ_W'(EXT_W);
    found = 1'b0;
    for (int i = EXT_W - 1; i >= 0; i--) begin
      if (!found && v[i]) begin
        lead_zeros = LZ_W'(EXT_W - 1 - i);
        found = 1'b1;
      end
    end
  endfunction

  function automatic logic [EXT_W-1:0] shr_sticky(input logic [EXT_W-1:0] v,
                                                  input logic [EXP_W-1:0] d);
    logic [EXT_W-1:0] mask;
    if (d >= EXP_W'(EXT_W)) begin
      shr_sticky = {{(EXT_W-1){1'b0}}, |v};
    end else begin
      mask = (EXT_W'(1) << d) - EXT_W'(1);
      shr_sticky = (v >> d) | {{(EXT_W-1){1'b0}}, |(v & mask)};
    end
  endfunction
endpackage

// File: rtl/fpadd_unpack.sv
module fpadd_unpack
  import fpadd_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              flip,
  output opnd_t             o
);
  logic [EXP_W-1:0]  e;
  logic [FRAC_W-1:0] f;

  assign e = word[WORD_W-2 -: EXP_W];
  assign f = word[FRAC_W-1:0];

  always_comb begin
    o.sign = word[WORD_W-1] ^ flip;
    o.exp  = (e == '0) ? EXP_W'(1) : e;
    o.sig  = {e != '0, f};
    o.nan  = (e == EXP_TOP) && (f != '0);
    o.inf  = (e == EXP_TOP) && (f == '0);
    o.zero = (e == '0) && (f == '0);
  end
endmodule

// File: rtl/fpadd_core.sv
module fpadd_core
  import fpadd_pkg::*;
(
  input  opnd_t             x,
  input  opnd_t             y,
  output logic [WORD_W-1:0] res,
  output logic              ovf,
  output logic              unf,
  output logic              rnd_carry
);
  opnd_t            big, sml;
  logic             x_big, eff_sub, zero_sum, sign_r;
  logic [EXP_W-1:0] d;
  logic [EXT_W-1:0] ma, mb, norm;
  logic [EXT_W:0]   sum;
  logic [LZ_W-1:0]  lz;
  logic [EW-1:0]    lim, sh, e_n, e_f;
  logic [SIG_W-1:0] mant, mant_f;
  logic [SIG_W:0]   mant_r;
  logic             g, r, s, inexact, up, tiny;

  always_comb begin
    x_big   = {x.exp, x.sig} >= {y.exp, y.sig};
    big     = x_big ? x : y;
    sml     = x_big ? y : x;
    eff_sub = x.sign ^ y.sign;
    d       = big.exp - sml.exp;
    ma      = {big.sig, 3'b000};
    mb      = shr_sticky({sml.sig, 3'b000}, d);
    sum     = eff_sub ? ({1'b0, ma} - {1'b0, mb}) : ({1'b0, ma} + {1'b0, mb});
    zero_sum = (sum == '0);
    lz  = lead_zeros(sum[EXT_W-1:0]);
    lim = EW'(big.exp) - EW'(1);
    sh  = '0;
    if (sum[EXT_W]) begin
      norm = {sum[EXT_W:2], sum[1] | sum[0]};
      e_n  = EW'(big.exp) + EW'(1);
    end else begin
      sh   = (EW'(lz) > lim) ? lim : EW'(lz);
      norm = sum[EXT_W-1:0] << sh;
      e_n  = EW'(big.exp) - sh;
    end
    mant    = norm[EXT_W-1:3];
    g       = norm[2];
    r       = norm[1];
    s       = norm[0];
    inexact = g | r | s;
    up      = g & (r | s | mant[0]);
    mant_r  = {1'b0, mant} + (SIG_W+1)'(up);
    rnd_carry = mant_r[SIG_W];
    if (rnd_carry) begin
      mant_f = mant_r[SIG_W:1];
      e_f    = e_n + EW'(1);
    end else begin
      mant_f = mant_r[SIG_W-1:0];
      e_f    = e_n;
    end
    tiny   = !mant_f[SIG_W-1];
    sign_r = (zero_sum && eff_sub) ? 1'b0 : big.sign;
    ovf    = (e_f >= EW'(EXP_TOP));
    unf    = tiny & inexact;
    if (ovf) res = {sign_r, EXP_TOP, {FRAC_W{1'b0}}};
    else     res = {sign_r, tiny ? {EXP_W{1'b0}} : e_f[EXP_W-1:0], mant_f[FRAC_W-1:0]};
  end
endmodule

// File: rtl/fp_add_sp.sv
module fp_add_sp
  import fpadd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              op,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic              out_valid,
  output logic [WORD_W-1:0] result,
  output logic              ovf,
  output logic              unf,
  output logic              inv
);
  opnd_t             ua, ub;
  logic [WORD_W-1:0] core_res, nxt_res;
  logic              core_ovf, core_unf, rnd_carry;
  logic              nan_case, inf_case, nxt_ovf, nxt_unf;

  fpadd_unpack u_ua (.word(a), .flip(1'b0), .o(ua));
  fpadd_unpack u_ub (.word(b), .flip(op),   .o(ub));

  fpadd_core u_core (
    .x(ua), .y(ub), .res(core_res),
    .ovf(core_ovf), .unf(core_unf), .rnd_carry(rnd_carry)
  );

  assign nan_case = ua.nan | ub.nan | (ua.inf & ub.inf & (ua.sign ^ ub.sign));
  assign inf_case = ua.inf | ub.inf;

  always_comb begin
    nxt_ovf = 1'b0;
    nxt_unf = 1'b0;
    if (nan_case)      nxt_res = QNAN;
    else if (inf_case) nxt_res = {ua.inf ? ua.sign : ub.sign, EXP_TOP, {FRAC_W{1'b0}}};
    else begin
      nxt_res = core_res;
      nxt_ovf = core_ovf;
      nxt_unf = core_unf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf       <= 1'b0;
      unf       <= 1'b0;
      inv       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      ovf       <= in_valid & nxt_ovf;
      unf       <= in_valid & nxt_unf;
      inv       <= in_valid & nan_case;
      if (in_valid) result <= nxt_res;
    end
  end
endmodule

// File: rtl/fpadd_chk.sv
module fpadd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        nan_case,
  input logic        out_valid,
  input logic [31:0] result,
  input logic        ovf,
  input logic        unf,
  input logic        inv
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R11
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> !(ovf | unf | inv)); // R11
  AST_INVALID_QNAN: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && inv) |-> result == 32'h7FC00000); // R7
  AST_NAN_RAISES_INV: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && nan_case) |=> inv); // R7
  AST_OVERFLOW_INF: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && ovf) |-> result[30:0] == 31'h7F800000); // R6
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $onehot0({ovf, unf, inv})); // R6
  AST_UNDERFLOW_TINY: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && unf) |-> result[30:23] == 8'h00); // R10
  AST_TOP_EXP_INF: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !inv && result[30:23] == 8'hFF) |-> result[22:0] == 23'h0); // R8
endmodule

bind fp_add_sp fpadd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .nan_case(nan_case),
  .out_valid(out_valid), .result(result), .ovf(ovf), .unf(unf), .inv(inv)
);

// File: tb/tb_fp_add_sp.sv
`timescale 1ns/1ps
module tb_fp_add_sp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        op = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        out_valid, ovf, unf, inv;
  logic [31:0] result;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  fp_add_sp dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a), .b(b),
    .out_valid(out_valid), .result(result), .ovf(ovf), .unf(unf), .inv(inv)
  );

  localparam int NV = 25;
  // {op, a, b, expected result, expected {ovf,unf,inv}}
  localparam logic [99:0] VEC [NV] = '{
    {1'b0, 32'h3F400000, 32'h40880000, 32'h40A00000, 3'b000}, // R1 0.75+4.25
    {1'b0, 32'h3F800000, 32'h3F800000, 32'h40000000, 3'b000}, // R1
    {1'b1, 32'h40A00000, 32'h3F400000, 32'h40880000, 3'b000}, // R2 subtract
    {1'b0, 32'h3F800000, 32'hBF400000, 32'h3E800000, 3'b000}, // R2 mixed signs
    {1'b0, 32'hC14A0000, 32'h41C40000, 32'h413E0000, 3'b000}, // R2 left normalise
    {1'b0, 32'h3F800000, 32'h30800000, 32'h3F800000, 3'b000}, // R3 far shift
    {1'b0, 32'h3F800000, 32'h33800000, 32'h3F800000, 3'b000}, // R4 tie even
    {1'b0, 32'h3F800001, 32'h33800000, 32'h3F800002, 3'b000}, // R4 tie odd
    {1'b0, 32'h3F800000, 32'h33800001, 32'h3F800001, 3'b000}, // R4 above half
    {1'b0, 32'h3FFFFFFF, 32'h33800000, 32'h40000000, 3'b000}, // R5 carry
    {1'b0, 32'h7F7FFFFF, 32'h73000000, 32'h7F800000, 3'b100}, // R6 carry+overflow
    {1'b0, 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, 3'b100}, // R6
    {1'b1, 32'hFF7FFFFF, 32'h7F7FFFFF, 32'hFF800000, 3'b100}, // R6 negative
    {1'b0, 32'h7F800001, 32'h3F800000, 32'h7FC00000, 3'b001}, // R7 NaN in
    {1'b1, 32'h7F800000, 32'h7F800000, 32'h7FC00000, 3'b001}, // R7 inf-inf
    {1'b0, 32'h7F800000, 32'hFF800000, 32'h7FC00000, 3'b001}, // R7
    {1'b0, 32'h7F800000, 32'h3F800000, 32'h7F800000, 3'b000}, // R8
    {1'b1, 32'h40A00000, 32'h7F800000, 32'hFF800000, 3'b000}, // R8
    {1'b1, 32'h40A00000, 32'h40A00000, 32'h00000000, 3'b000}, // R9 cancel
    {1'b0, 32'h80000000, 32'h80000000, 32'h80000000, 3'b000}, // R9
    {1'b0, 32'h80000000, 32'h00000000, 32'h00000000, 3'b000}, // R9
    {1'b0, 32'h3F800000, 32'h00000000, 32'h3F800000, 3'b000}, // R9 zero operand
    {1'b0, 32'h00000001, 32'h00000001, 32'h00000002, 3'b000}, // R10
    {1'b1, 32'h00800000, 32'h00000001, 32'h007FFFFF, 3'b000}, // R10
    {1'b0, 32'h00400000, 32'h00400000, 32'h00800000, 3'b000}  // R10
  };
  string tags [NV];

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got {valid,ovf,unf,inv,result}=%h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    tags = '{"R1","R1","R2","R2","R2","R3","R4","R4","R4","R5","R6","R6","R6",
             "R7","R7","R7","R8","R8","R9","R9","R9","R9","R10","R10","R10"};
    repeat (3) @(negedge clk);
    check("R11 reset", {out_valid, ovf, unf, inv, 32'h0}, 36'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1;
      op = VEC[i][99];
      a  = VEC[i][98:67];
      b  = VEC[i][66:35];
      @(negedge clk);
      check(tags[i], {out_valid, ovf, unf, inv, result},
            {1'b1, VEC[i][2:0], VEC[i][34:3]});
    end
    // R11: flags clear once the request stream stops (last was a flagged op)
    in_valid = 1'b1; op = 1'b0; a = 32'h7F7FFFFF; b = 32'h7F7FFFFF;
    @(negedge clk);
    check("R6 back-to-back", {out_valid, ovf, unf, inv, result}, {4'b1100, 32'h7F800000});
    in_valid = 1'b0;
    @(negedge clk);
    check("R11 idle", {out_valid, ovf, unf, inv, 32'h0}, 36'h0);
    in_valid = 1'b1; a = 32'h7F800001;
    @(negedge clk);
    check("R7 after idle", {out_valid, ovf, unf, inv, result}, {4'b1001, 32'h7FC00000});
    rst_n = 1'b0;
    #1;
    check("R11 async reset", {out_valid, ovf, unf, inv, 32'h0}, 36'h0);
    in_valid = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule